// File: doc/BRIEF.md
# Range Bin Decimator with Stall Watchdog

This block shrinks one frame of range samples into a fixed set of output bins. Each frame begins with the first valid sample after the block is idle. It discards a programmable number of leading samples, then folds every run of 16 accepted samples into one output bin until 64 bins have been emitted. Each bin either carries the centre sample of its group or the group's strongest sample, measured by |I|+|Q|.

The mode and the skip count are captured on the first sample of a frame and stay fixed until the frame ends. If the upstream source stops in the middle of a frame, a watchdog counts clocks that have no valid strobe. After 256 such clocks in a row it abandons the frame, emits a one-clock timeout pulse and returns to idle. The next frame then starts cleanly from bin 0.

Top module: `rbin_decimator`

## Requirements
- R1: While reset is high and on the first clock after it, `out_valid` and `timeout` are low.
- R2: The first `start_bin` valid samples of a frame are discarded; decimation begins with sample number `start_bin` (start_bin 0 means no skipping).
- R3: Each output bin is built from 16 consecutive accepted samples. A frame yields 64 bins with `out_bin` counting 0 to 63 in order. `out_valid` is high for exactly one clock, on the clock after the 16th sample of the group.
- R4: With mode code 00, 10 or 11, a bin carries the I and Q of the group's sample at position 8 (positions count 0 to 15).
- R5: With mode code 01, a bin carries the I and Q of the one group sample with the largest |I|+|Q|, where -32768 counts as 32768. On a tie the earliest sample wins. A ramp 0..15 in the first group gives 15 in bin 0.
- R6: Changes to `mode` or `start_bin` after the first sample of a frame do not affect that frame.
- R7: If 256 consecutive clocks pass without a valid sample while skipping or decimating, `timeout` is high for exactly one clock, on the clock after the 256th idle clock. The partial frame is dropped and the block returns to idle.
- R8: Gaps of up to 255 clocks between valid samples never trigger the timeout and lose no output.
- R9: `timeout` never rises while the block is idle, however long no sample arrives.
- R10: After a timeout, the next complete frame produces all 64 correct bins starting at bin 0.
- R11: After bin 63 the block is idle. The next valid sample, even on the very next clock, starts a new frame and re-captures mode and start bin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | Signed in-phase sample |
| in_q | input | 16 | Signed quadrature sample |
| mode | input | 2 | 01 = peak, other codes = centre pick |
| start_bin | input | 10 | Number of leading samples to discard |
| out_valid | output | 1 | One-clock strobe per output bin |
| out_i | output | 16 | Signed in-phase result |
| out_q | output | 16 | Signed quadrature result |
| out_bin | output | 6 | Index of the bin being emitted |
| timeout | output | 1 | One-clock pulse when a stalled frame is abandoned |

## Verification
The assertions assume that `in_valid` is a clean single-bit strobe and that a timeout can only follow a run of clocks with no strobe. They also assume that reset is held long enough to clear every counter before the first sample. The stimulus drives samples and control only on the falling edge and never lets `in_valid` go unknown. It produces both short gaps and stalls that are plainly longer than the watchdog window, so every timeout the checker sees comes from a genuine 256-clock silence. Mid-frame changes to mode and start bin are applied only while a frame is in flight, so the capture-at-first-sample rule is what decides the outcome.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SKIP = 2'd1,
    ST_PROC = 2'd2
  } rbd_state_e;

  // mode code that selects strongest-sample reduction; all others pick centre
  localparam logic [1:0] MODE_PEAK = 2'b01;
endpackage

// File: rtl/rbd_watchdog.sv
module rbd_watchdog #(
  parameter  int LIMIT = 256,
  localparam int CW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic kick,
  output logic expire
);
  logic [CW-1:0] quiet_cnt;

  // fires on the LIMIT-th consecutive clock without a kick while active
  assign expire = active && !kick && (quiet_cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !active || kick || expire)
      quiet_cnt <= '0;
    else
      quiet_cnt <= quiet_cnt + 1'b1;
  end
endmodule

// File: rtl/rbd_ctrl.sv
module rbd_ctrl
  import rbd_pkg::*;
#(
  parameter  int GROUP_LEN = 16,
  parameter  int OUT_BINS  = 64,
  parameter  int START_W   = 10,
  localparam int GW        = $clog2(GROUP_LEN),
  localparam int IW        = $clog2(OUT_BINS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [START_W-1:0] start_in,
  input  logic [1:0]         mode_in,
  input  logic               expire,
  output logic               active,
  output logic               take,
  output logic               grp_first,
  output logic               grp_pick,
  output logic               grp_last,
  output logic               peak_mode,
  output logic [IW-1:0]      bin
);
  localparam int             CENTER = GROUP_LEN / 2;
  localparam logic [GW-1:0]  G_LAST = GW'(GROUP_LEN - 1);
  localparam logic [GW-1:0]  G_CTR  = GW'(CENTER);
  localparam logic [IW-1:0]  B_LAST = IW'(OUT_BINS - 1);

  rbd_state_e         state;
  logic [START_W-1:0] start_q;
  logic [START_W-1:0] skip_cnt;
  logic [START_W-1:0] skip_nxt;
  logic [1:0]         mode_q;
  logic [GW-1:0]      gidx;

  assign active    = (state != ST_IDLE);
  // a sample is decimated when already processing, or when it opens a
  // frame that has nothing to skip
  assign take      = in_valid && ((state == ST_PROC) ||
                                  (state == ST_IDLE && start_in == '0));
  assign grp_first = (gidx == '0);
  assign grp_pick  = (gidx == G_CTR);
  assign grp_last  = take && (gidx == G_LAST);
  assign peak_mode = (((state == ST_IDLE) ? mode_in : mode_q) == MODE_PEAK);
  assign skip_nxt  = (state == ST_IDLE) ? START_W'(1) : skip_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      start_q  <= '0;
      mode_q   <= '0;
      skip_cnt <= '0;
      gidx     <= '0;
      bin      <= '0;
    end else if (expire) begin
      state    <= ST_IDLE;
      skip_cnt <= '0;
      gidx     <= '0;
      bin      <= '0;
    end else begin
      if (take) begin
        if (gidx == G_LAST) begin
          gidx <= '0;
          bin  <= (bin == B_LAST) ? '0 : bin + 1'b1;
        end else begin
          gidx <= gidx + 1'b1;
        end
      end
      unique case (state)
        ST_IDLE: begin
          if (in_valid) begin
            start_q <= start_in;
            mode_q  <= mode_in;
            if (start_in == '0) begin
              state <= ST_PROC;
            end else begin
              skip_cnt <= skip_nxt;
              state    <= (skip_nxt == start_in) ? ST_PROC : ST_SKIP;
            end
          end
        end
        ST_SKIP: begin
          if (in_valid) begin
            skip_cnt <= skip_nxt;
            if (skip_nxt == start_q) state <= ST_PROC;
          end
        end
        ST_PROC: begin
          if (grp_last && bin == B_LAST) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rbd_reduce.sv
module rbd_reduce #(
  parameter  int DATA_W = 16,
  localparam int MW     = DATA_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     take,
  input  logic                     first,
  input  logic                     pick,
  input  logic                     peak_mode,
  input  logic signed [DATA_W-1:0] in_i,
  input  logic signed [DATA_W-1:0] in_q,
  output logic signed [DATA_W-1:0] res_i,
  output logic signed [DATA_W-1:0] res_q
);
  logic signed [DATA_W-1:0] lane_in  [2];
  logic        [MW-1:0]     lane_abs [2];
  logic signed [DATA_W-1:0] lane_res [2];
  logic        [MW:0]       cur_mag;
  logic        [MW:0]       best_mag;
  logic                     beat;

  assign lane_in[0] = in_i;
  assign lane_in[1] = in_q;

  assign cur_mag = {1'b0, lane_abs[0]} + {1'b0, lane_abs[1]};
  // strictly larger replaces, so the earliest of equal magnitudes stays
  assign beat    = first || (cur_mag > best_mag);

  for (genvar k = 0; k < 2; k++) begin : g_lane
    logic signed [DATA_W-1:0] best_r;
    logic signed [DATA_W-1:0] pick_r;
    logic signed [MW-1:0]     ext;
    logic signed [DATA_W-1:0] peak_now;
    logic signed [DATA_W-1:0] pick_now;

    assign ext         = MW'(lane_in[k]);
    assign lane_abs[k] = ext[MW-1] ? $unsigned(-ext) : $unsigned(ext);
    assign peak_now    = beat ? lane_in[k] : best_r;
    assign pick_now    = pick ? lane_in[k] : pick_r;
    assign lane_res[k] = peak_mode ? peak_now : pick_now;

    always_ff @(posedge clk) begin
      if (rst) begin
        best_r <= '0;
        pick_r <= '0;
      end else if (take) begin
        if (beat) best_r <= lane_in[k];
        if (pick) pick_r <= lane_in[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      best_mag <= '0;
    else if (take && beat)
      best_mag <= cur_mag;
  end

  assign res_i = lane_res[0];
  assign res_q = lane_res[1];
endmodule

// File: rtl/rbin_decimator.sv
module rbin_decimator
  import rbd_pkg::*;
#(
  parameter  int DATA_W    = 16,
  parameter  int GROUP_LEN = 16,
  parameter  int OUT_BINS  = 64,
  parameter  int START_W   = 10,
  parameter  int WD_LIMIT  = 256,
  localparam int IW        = $clog2(OUT_BINS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_i,
  input  logic signed [DATA_W-1:0] in_q,
  input  logic [1:0]               mode,
  input  logic [START_W-1:0]       start_bin,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_i,
  output logic signed [DATA_W-1:0] out_q,
  output logic [IW-1:0]            out_bin,
  output logic                     timeout
);
  logic                     active;
  logic                     st_idle;
  logic                     take;
  logic                     grp_first;
  logic                     grp_pick;
  logic                     grp_last;
  logic                     peak_mode;
  logic                     expire;
  logic [IW-1:0]            bin;
  logic signed [DATA_W-1:0] res_i;
  logic signed [DATA_W-1:0] res_q;

  assign st_idle = !active;

  rbd_ctrl #(
    .GROUP_LEN (GROUP_LEN),
    .OUT_BINS  (OUT_BINS),
    .START_W   (START_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .start_in  (start_bin),
    .mode_in   (mode),
    .expire    (expire),
    .active    (active),
    .take      (take),
    .grp_first (grp_first),
    .grp_pick  (grp_pick),
    .grp_last  (grp_last),
    .peak_mode (peak_mode),
    .bin       (bin)
  );

  rbd_reduce #(
    .DATA_W (DATA_W)
  ) u_reduce (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .first     (grp_first),
    .pick      (grp_pick),
    .peak_mode (peak_mode),
    .in_i      (in_i),
    .in_q      (in_q),
    .res_i     (res_i),
    .res_q     (res_q)
  );

  rbd_watchdog #(
    .LIMIT (WD_LIMIT)
  ) u_wdog (
    .clk    (clk),
    .rst    (rst),
    .active (active),
    .kick   (in_valid),
    .expire (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
      out_bin   <= '0;
      timeout   <= 1'b0;
    end else begin
      out_valid <= grp_last;
      timeout   <= expire;
      if (grp_last) begin
        out_i   <= res_i;
        out_q   <= res_q;
        out_bin <= bin;
      end
    end
  end
endmodule

// File: rtl/rbin_decimator_chk.sv
module rbin_decimator_chk #(
  parameter  int WD_LIMIT = 256,
  localparam int GCW      = $clog2(WD_LIMIT + 2)
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic out_valid,
  input logic timeout,
  input logic st_idle
);
  // clocks since the last valid sample, saturating just past the window
  logic [GCW-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst || in_valid)
      gap_cnt <= '0;
    else if (gap_cnt != GCW'(WD_LIMIT + 1))
      gap_cnt <= gap_cnt + 1'b1;
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!out_valid && !timeout));

  a_r3_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  a_r7_timeout_one_cycle: assert property (@(posedge clk) disable iff (rst)
    timeout |=> !timeout);

  a_r7_timeout_not_with_output: assert property (@(posedge clk) disable iff (rst)
    timeout |-> !out_valid);

  // R7 / R8: a timeout only ever follows exactly the full quiet window
  a_r8_full_window_before_timeout: assert property (@(posedge clk) disable iff (rst)
    timeout |-> (gap_cnt == GCW'(WD_LIMIT)));

  a_r9_idle_never_times_out: assert property (@(posedge clk) disable iff (rst)
    (st_idle && !in_valid) |=> !timeout);
endmodule

bind rbin_decimator rbin_decimator_chk #(
  .WD_LIMIT (WD_LIMIT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .timeout   (timeout),
  .st_idle   (st_idle)
);

// File: tb/rbin_decimator_tb.sv
`timescale 1ns/1ps
module rbin_decimator_tb;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               vin = 1'b0;
  logic signed [15:0] si  = '0;
  logic signed [15:0] sq  = '0;
  logic [1:0]         md  = 2'b00;
  logic [9:0]         sb  = '0;
  logic               out_valid;
  logic signed [15:0] out_i;
  logic signed [15:0] out_q;
  logic [5:0]         out_bin;
  logic               timeout;

  always #2 clk = ~clk;

  rbin_decimator u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (vin),
    .in_i      (si),
    .in_q      (sq),
    .mode      (md),
    .start_bin (sb),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q),
    .out_bin   (out_bin),
    .timeout   (timeout)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit cmp_on = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_st = 0, m_skip = 0, m_start = 0, m_mode = 0, m_g = 0, m_bin = 0, m_idle = 0;
  int b_i = 0, b_q = 0, b_mag = 0, s_i = 0, s_q = 0;
  bit e_v = 0, e_to = 0;
  int e_i = 0, e_q = 0, e_bin = 0;

  function automatic int absv(input int x);
    return (x < 0) ? -x : x;
  endfunction

  task automatic m_take(input int xi, input int xq);
    int mg;
    mg = absv(xi) + absv(xq);
    if (m_g == 0 || mg > b_mag) begin
      b_i = xi; b_q = xq; b_mag = mg;
    end
    if (m_g == 8) begin
      s_i = xi; s_q = xq;
    end
    if (m_g == 15) begin
      e_v   = 1;
      e_i   = (m_mode == 1) ? b_i : s_i;
      e_q   = (m_mode == 1) ? b_q : s_q;
      e_bin = m_bin;
      m_g   = 0;
      m_bin++;
      if (m_bin == 64) begin
        m_bin = 0;
        m_st  = 0;
      end
    end else begin
      m_g++;
    end
  endtask

  always @(posedge clk) begin
    e_v  = 0;
    e_to = 0;
    if (rst) begin
      m_st = 0; m_g = 0; m_bin = 0; m_idle = 0; m_skip = 0;
    end else if (m_st == 0) begin
      if (vin) begin
        m_start = int'(sb); m_mode = int'(md);
        m_idle = 0; m_g = 0; m_bin = 0;
        if (sb == 0) begin
          m_st = 2;
          m_take(int'(si), int'(sq));
        end else begin
          m_skip = 1;
          m_st   = (sb == 1) ? 2 : 1;
        end
      end
    end else begin
      if (vin) begin
        m_idle = 0;
        if (m_st == 1) begin
          m_skip++;
          if (m_skip == m_start) m_st = 2;
        end else begin
          m_take(int'(si), int'(sq));
        end
      end else begin
        m_idle++;
        if (m_idle == 256) begin
          e_to = 1; m_st = 0; m_idle = 0; m_g = 0; m_bin = 0;
        end
      end
    end
  end

  // ---------------- per-clock comparison and monitors ----------------
  int n_out = 0, n_to = 0, first_i = -99999;

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(out_valid == e_v, "R3 out_valid", int'(out_valid), int'(e_v));
      chk(timeout == e_to, "R7 timeout", int'(timeout), int'(e_to));
      if (out_valid && e_v) begin
        chk(int'(out_bin) == e_bin, "R3 out_bin", int'(out_bin), e_bin);
        chk(int'(out_i) == e_i, (m_mode == 1) ? "R5 out_i" : "R4 out_i", int'(out_i), e_i);
        chk(int'(out_q) == e_q, (m_mode == 1) ? "R5 out_q" : "R4 out_q", int'(out_q), e_q);
      end
      if (out_valid) begin
        n_out++;
        if (out_bin == 0) first_i = int'(out_i);
      end
      if (timeout) n_to++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  // kind 0: pseudo-random with extremes, 1: ramp on I, 2: equal magnitudes
  function automatic int gen(input int kind, input int seed, input int k, input bit qlane);
    if (kind == 1) return qlane ? 0 : (k % 1024);
    if (kind == 2) return qlane ? ((k % 3 == 0) ? 100 : -100) : ((k % 2 == 1) ? 300 : -300);
    if (k % 97 == 5)  return -32768;
    if (k % 89 == 3)  return 32767;
    return ((k * (seed * 7919 + 13) + seed * 31 + (qlane ? 577 : 0)) % 4001) - 2000;
  endfunction

  task automatic feed(input int n, input int kind, input int seed,
                      input int gap_every, input int gap_len);
    for (int k = 0; k < n; k++) begin
      si  = 16'(gen(kind, seed, k, 1'b0));
      sq  = 16'(gen(kind, seed, k, 1'b1));
      vin = 1'b1;
      @(negedge clk);
      if (gap_every > 0 && ((k + 1) % gap_every) == 0 && k + 1 < n) begin
        vin = 1'b0;
        repeat (gap_len) @(negedge clk);
      end
    end
    vin = 1'b0;
  endtask

  task automatic settle_clear();
    repeat (4) @(negedge clk);
    n_out = 0;
    n_to = 0;
    first_i = -99999;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cmp_on = 1;
    chk(!out_valid && !timeout, "R1 reset outputs", int'(out_valid) + int'(timeout), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && !timeout, "R1 after reset", int'(out_valid) + int'(timeout), 0);
    settle_clear();

    // R5: ramp in peak mode, bin 0 holds 15
    md = 2'b01; sb = 10'd0;
    feed(1024, 1, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(n_out == 64, "R3 bins per frame", n_out, 64);
    chk(first_i == 15, "R5 ramp peak bin0", first_i, 15);
    settle_clear();

    // R2 / R4: centre pick with skip and short gaps
    md = 2'b00; sb = 10'd5;
    feed(5 + 1024, 0, 3, 7, 3);
    repeat (3) @(negedge clk);
    chk(n_out == 64, "R2 skip then 64 bins", n_out, 64);
    settle_clear();

    // R5: peak with signed extremes, then all-equal magnitudes (earliest wins)
    md = 2'b01; sb = 10'd0;
    feed(1024, 0, 5, 0, 0);
    settle_clear();
    md = 2'b01; sb = 10'd1;
    feed(1 + 1024, 2, 0, 0, 0);
    settle_clear();

    // R4: other mode codes behave as centre pick
    md = 2'b10; sb = 10'd3;
    feed(3 + 1024, 0, 7, 0, 0);
    settle_clear();
    md = 2'b11; sb = 10'd0;
    feed(1024, 0, 9, 0, 0);
    settle_clear();

    // R6: controls changed mid-frame are ignored until the next frame
    md = 2'b00; sb = 10'd2;
    fork
      feed(2 + 1024, 0, 4, 0, 0);
      begin
        repeat (100) @(negedge clk);
        md = 2'b01;
        sb = 10'd700;
      end
    join
    repeat (3) @(negedge clk);
    chk(n_out == 64, "R6 frame unaffected by mid-frame change", n_out, 64);
    settle_clear();

    // R8: 20-clock gaps, then 255-clock gaps (one short of the window)
    md = 2'b01; sb = 10'd0;
    feed(1024, 0, 6, 50, 20);
    repeat (3) @(negedge clk);
    chk(n_to == 0 && n_out == 64, "R8 20-clock gaps", n_to * 1000 + n_out, 64);
    settle_clear();
    md = 2'b00; sb = 10'd4;
    feed(4 + 1024, 0, 8, 300, 255);
    repeat (3) @(negedge clk);
    chk(n_to == 0 && n_out == 64, "R8 255-clock gaps", n_to * 1000 + n_out, 64);
    settle_clear();

    // R7 / R10: stall mid-group while decimating, then a clean frame
    md = 2'b01; sb = 10'd0;
    feed(8, 1, 0, 0, 0);
    repeat (300) @(negedge clk);
    chk(n_to == 1, "R7 stall in process", n_to, 1);
    settle_clear();
    feed(1024, 1, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(n_out == 64, "R10 bins after timeout", n_out, 64);
    chk(first_i == 15, "R10 bin0 after timeout", first_i, 15);
    settle_clear();

    // R7 / R10: stall while still skipping
    md = 2'b00; sb = 10'd100;
    feed(50, 0, 2, 0, 0);
    repeat (300) @(negedge clk);
    chk(n_to == 1, "R7 stall in skip", n_to, 1);
    settle_clear();
    sb = 10'd0;
    feed(1024, 0, 2, 0, 0);
    repeat (3) @(negedge clk);
    chk(n_out == 64, "R10 bins after skip timeout", n_out, 64);
    settle_clear();

    // R9: long idle wait
    repeat (600) @(negedge clk);
    chk(n_to == 0, "R9 no timeout while idle", n_to, 0);
    settle_clear();

    // R11: two frames back to back with no gap
    md = 2'b00; sb = 10'd0;
    feed(2048, 0, 11, 0, 0);
    repeat (3) @(negedge clk);
    chk(n_out == 128, "R11 back-to-back frames", n_out, 128);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule